// File: doc/BRIEF.md
# Phase-Shared Carry-Select Adder

This block adds two unsigned operands and returns the full-width sum together with a carry-out. It follows the carry-select idea: the sum of the upper part is prepared for both possible incoming carries, and the real carry from the lower part picks one of them. It does not use two upper adders or an increment stage. Instead, one upper ripple adder is shared between the two halves of the clock period. The clock itself is that adder's carry-in.

While the clock is high, the upper adder produces its carry-in-one result. A bank of transparent-high latches follows this result and holds it once the clock falls. While the clock is low, the same adder produces its carry-in-zero result. The carry-out of a small ripple adder on the lowest bits then picks either the held result or the live one. The output is meaningful during a low phase that follows a complete high phase with unchanged operands. A user samples it in that window.

Top module: `phase_csel_adder`

## Requirements
- R1: During a clock-low phase that follows a full high phase with unchanged operands, {cout, sum} equals a + b as a WIDTH+1 bit unsigned value (WIDTH = 16 by default).
- R2: The carry-in of the upper adder (bits WIDTH-1 down to LOW_W, LOW_W = 2 by default) is the clock. While the clock is high and the low-part carry is 0, {cout, sum[WIDTH-1:LOW_W]} equals the upper operand bits added with a carry of 1.
- R3: While the clock is low and the low-part carry is 0, the upper output follows the live carry-in-zero sum of the current operands, including operands changed within that low phase.
- R4: While the clock is low, the latched result keeps the carry-in-one sum of the operands present at the end of the preceding high phase. Operands that change within the low phase and produce a low-part carry of 1 therefore yield that held upper value.
- R5: The low-part carry is the carry out of bits LOW_W-1 down to 0. When it is 1 the latched result drives cout and the upper sum bits; when it is 0 the live upper adder drives them.
- R6: The bits sum[LOW_W-1:0] always equal a[LOW_W-1:0] + b[LOW_W-1:0] modulo 2^LOW_W, in either clock phase.
- R7: While rst_n is low, the latches are cleared to zero. With a low-part carry of 1, {cout, sum[WIDTH-1:LOW_W]} is therefore zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; high phase computes and captures the carry-one result, and also acts as the upper adder's carry-in |
| rst_n | input | 1 | Active-low reset that clears the result latches |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the full addition |

## Verification
The assertions are sampled at rising edges, which see the end of a low phase. They compare the latched value and the total only when the operands seen at this edge match those seen at the previous edge. This relies on the assumption that the operands never change away and then return to the same value within one period. The stimulus applies each operand pair just after a rising edge. It changes operands inside a low phase only in the R3 and R4 cases, and the values it then moves to always differ from the ones held at the previous edge. This keeps every assertion antecedent honest.

// File: rtl/phase_csel_pkg.sv
package phase_csel_pkg;

  // One-bit full adder split into its two outputs.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  import phase_csel_pkg::*;

  // Bit-serial carry chain, least significant bit first.
  always_comb begin
    logic c;
    c = cin;
    s = '0;
    for (int i = 0; i < W; i++) begin
      s[i] = fa_sum(x[i], y[i], c);
      c    = fa_carry(x[i], y[i], c);
    end
    co = c;
  end

endmodule

// File: rtl/csel_latch_bank.sv
module csel_latch_bank #(
  parameter int W = 4
) (
  input  logic         en,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // One transparent-high latch per bit, cleared while reset is low.
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic q_bit;
      always_latch begin
        if (!rst_n)
          q_bit <= 1'b0;
        else if (en)
          q_bit <= d[i];
      end
      assign q[i] = q_bit;
    end
  endgenerate

endmodule

// File: rtl/csel_mux_bank.sv
module csel_mux_bank #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  output logic [W-1:0] out
);

  // A column of 2:1 selectors sharing a single select line.
  generate
    for (genvar i = 0; i < W; i++) begin : g_mux
      assign out[i] = sel ? in1[i] : in0[i];
    end
  endgenerate

endmodule

// File: rtl/phase_csel_adder.sv
module phase_csel_adder #(
  parameter int WIDTH = 16,
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int UP_W = WIDTH - LOW_W;

  // Reference arithmetic for the upper slice, used by the assertions.
  function automatic logic [UP_W:0] upper_add(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y,
                                              input logic             ci);
    return {1'b0, x[WIDTH-1:LOW_W]} + {1'b0, y[WIDTH-1:LOW_W]} + {{UP_W{1'b0}}, ci};
  endfunction

  // Named internal events.
  logic [LOW_W-1:0] lo_sum;
  logic             lo_carry;
  logic [UP_W-1:0]  up_live_sum;
  logic             up_live_cout;
  logic [UP_W:0]    up_live;
  logic [UP_W:0]    up_held;
  logic [UP_W:0]    up_pick;

  // Low slice: plain ripple adder with no carry-in.
  csel_ripple #(.W(LOW_W)) u_low (
    .x   (a[LOW_W-1:0]),
    .y   (b[LOW_W-1:0]),
    .cin (1'b0),
    .s   (lo_sum),
    .co  (lo_carry)
  );

  // Upper slice: the clock is the carry-in, so the phase picks the case.
  csel_ripple #(.W(UP_W)) u_up (
    .x   (a[WIDTH-1:LOW_W]),
    .y   (b[WIDTH-1:LOW_W]),
    .cin (clk),
    .s   (up_live_sum),
    .co  (up_live_cout)
  );

  assign up_live = {up_live_cout, up_live_sum};

  // Latches follow the carry-one result during the high phase.
  csel_latch_bank #(.W(UP_W + 1)) u_hold (
    .en    (clk),
    .rst_n (rst_n),
    .d     (up_live),
    .q     (up_held)
  );

  // The low-slice carry chooses the held or the live upper result.
  csel_mux_bank #(.W(UP_W + 1)) u_pick (
    .sel (lo_carry),
    .in0 (up_live),
    .in1 (up_held),
    .out (up_pick)
  );

  assign sum  = {up_pick[UP_W-1:0], lo_sum};
  assign cout = up_pick[UP_W];

  // Rising-edge samples observe the end of a low phase.
  p_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(a) && $stable(b)) |->
      ({cout, sum} == ({1'b0, a} + {1'b0, b})))
    else $error("p_total_r1");

  p_held_cin1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(a) && $stable(b)) |-> (up_held == upper_add(a, b, 1'b1)))
    else $error("p_held_cin1_r2");

  p_live_cin0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (up_live == upper_add(a, b, 1'b0)))
    else $error("p_live_cin0_r3");

  p_pick_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_carry |-> ({cout, sum[WIDTH-1:LOW_W]} == up_held))
    else $error("p_pick_held_r5");

  p_pick_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_carry |-> ({cout, sum[WIDTH-1:LOW_W]} == up_live))
    else $error("p_pick_live_r5");

  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (sum[LOW_W-1:0] == LOW_W'(a[LOW_W-1:0] + b[LOW_W-1:0])))
    else $error("p_low_bits_r6");

endmodule

// File: tb/phase_csel_adder_bench.sv
module phase_csel_adder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0, sum;
  logic        cout;
  logic [5:0]  as6 = '0, bs6 = '0, sum6;
  logic        cout6;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_csel_adder u_phase_csel_adder (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sum(sum), .cout(cout)
  );

  phase_csel_adder #(.WIDTH(6), .LOW_W(2)) u_small (
    .clk(clk), .rst_n(rst_n), .a(as6), .b(bs6), .sum(sum6), .cout(cout6)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // R1: operands applied in the high phase, result read mid low phase.
  task automatic run_full(input logic [15:0] x, input logic [15:0] y);
    @(posedge clk); #1;
    a = x; b = y;
    @(negedge clk); #2;
    check("R1 R5 sum", {15'd0, cout, sum}, {15'd0, 17'({1'b0, x} + {1'b0, y})});
  endtask

  // R2 and R6: operands with no low carry, read mid high phase.
  task automatic run_high(input logic [15:0] x, input logic [15:0] y);
    @(posedge clk); #1;
    a = x; b = y;
    #2;
    check("R2 high", {15'd0, cout, sum}, {15'd0, 17'({1'b0, x} + {1'b0, y} + 17'd4)});
    check("R6 low bits", {30'd0, sum[1:0]}, {30'd0, 2'(x[1:0] + y[1:0])});
    @(negedge clk); #2;
    check("R1 after high", {15'd0, cout, sum}, {15'd0, 17'({1'b0, x} + {1'b0, y})});
  endtask

  // R3 and R4: change operands inside the low phase.
  task automatic run_mid(input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] z, input logic [15:0] w);
    logic [2:0]  low;
    logic [14:0] held;
    @(posedge clk); #1;
    a = x; b = y;
    @(negedge clk); #2;
    check("R1 pre", {15'd0, cout, sum}, {15'd0, 17'({1'b0, x} + {1'b0, y})});
    #1;
    a = z; b = w;
    #1;
    low = {1'b0, z[1:0]} + {1'b0, w[1:0]};
    if (!low[2]) begin
      check("R3 live", {15'd0, cout, sum}, {15'd0, 17'({1'b0, z} + {1'b0, w})});
    end else begin
      held = {1'b0, x[15:2]} + {1'b0, y[15:2]} + 15'd1;
      check("R4 held", {15'd0, cout, sum}, {15'd0, held, low[1:0]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset clears the latches, so a low carry of 1 selects zero.
    a = 16'h0003; b = 16'h0001;
    repeat (2) @(posedge clk);
    #3;
    check("R7 reset high", {15'd0, cout, sum}, 32'd0);
    @(negedge clk); #2;
    check("R7 reset low", {15'd0, cout, sum}, 32'd0);
    a = 16'hFFFF; b = 16'h0001;
    #1;
    check("R7 reset wide", {15'd0, cout, sum}, 32'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R1 and R5 directed corners.
    run_full(16'h0000, 16'h0000);
    run_full(16'hFFFF, 16'h0001);
    run_full(16'hFFFF, 16'hFFFF);
    run_full(16'h0003, 16'h0001);
    run_full(16'h7FFF, 16'h0001);
    run_full(16'hAAAA, 16'h5555);
    run_full(16'h1234, 16'h0FFC);
    run_full(16'h8000, 16'h8000);

    // R2 and R6.
    run_high(16'h1234, 16'h0001);
    run_high(16'hFFFC, 16'h0003);
    run_high(16'h4000, 16'h0000);

    // R3 and R4.
    run_mid(16'h1000, 16'h2000, 16'h0401, 16'h0002);
    run_mid(16'hFFF0, 16'h000F, 16'h0003, 16'h0001);
    run_mid(16'h0100, 16'h0200, 16'h0002, 16'h0003);

    // R1 random operands.
    for (int k = 0; k < 200; k++) begin
      run_full(16'($urandom), 16'($urandom));
    end

    // R1 and R5: exhaustive sweep of the 6-bit configuration.
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        @(posedge clk); #1;
        as6 = 6'(i); bs6 = 6'(j);
        @(negedge clk); #2;
        check("R1 R5 small", {25'd0, cout6, sum6}, 32'(i + j));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule